// File: doc/BRIEF.md
# Memory CRC-8 Validation Engine

The engine proves the integrity of a small non-volatile byte array. The highest location of the array holds a checksum. Every other location is covered by a CRC-8 that the engine computes by reading the array in ascending address order through a synchronous read port with one cycle of latency. Once it has read the checksum byte, the engine compares it with the computed value. It reports the outcome on two status flags, one for a check in progress and one for a match. It also presents the computed value.

Three events start a check. The first is the end of reset, so a check always runs once at power-up. The second is any write to the checksum location, which the engine sees on the array's write strobe and address. The third is a calculate request bit that software sets and that clears itself once the check it asks for has been accepted. A request that arrives while a check is running is held and served as soon as that check ends. Any number of requests that arrive during one check are merged into a single follow-up check.

Top module: `memcrc_engine`

## Requirements
- R1: While reset is asserted, `busy`, `good`, `calc_req` and `rd_en` are 0. With no other stimulus, a check starts at the first clock edge after reset is released.
- R2: A write (`wr_en`=1) to address DEPTH-1 starts a check. A write to any other address starts none and leaves `good` and `busy` unchanged.
- R3: A pulse on `calc_set` sets `calc_req`. `calc_req` stays at 1 until the edge at which its check starts, and it clears at that edge.
- R4: At completion, `crc_value` equals the CRC-8 of bytes 0 to DEPTH-2 taken in ascending address order. The CRC uses generator x^8+x^2+x+1 (0x07), starts from 0xFF, feeds each byte most significant bit first and applies no final inversion.
- R5: At completion, `good` is 1 exactly when the computed CRC equals the byte read from address DEPTH-1. `good` changes only at the start or the end of a check.
- R6: `good` is 0 from the edge at which a check starts until that check ends.
- R7: A check keeps `busy` high for exactly DEPTH+1 cycles. It asserts `rd_en` only while busy and issues the addresses 0 to DEPTH-1 once each, one per cycle, in ascending order.
- R8: A trigger that arrives while `busy` is high is not lost. The next check starts one idle cycle after `busy` falls, and several such triggers produce only one further check.
- R9: A trigger sampled at clock edge T while idle makes `busy` rise at edge T+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Array write strobe, observed only |
| wr_addr | input | ADDR_W | Array write address, observed only |
| calc_set | input | 1 | Software pulse that sets the calculate request bit |
| calc_req | output | 1 | Calculate request bit, cleared when its check starts |
| rd_en | output | 1 | Array read enable |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | DATA_W | Array read data, valid one cycle after `rd_en` |
| busy | output | 1 | Check in progress |
| good | output | 1 | Last completed check matched the stored byte |
| crc_value | output | DATA_W | CRC computed by the last completed check |

## Verification
A trigger sampled at edge T sets a pending flag, so `busy` rises at edge T+1. The bench therefore reads `calc_req` one negative edge after the trigger and `busy` one negative edge after that. From the rise, `busy` is high for DEPTH+1 edges: DEPTH of them issue reads, and the final data byte arrives on the last one. The bench counts the negative edges that show `busy` high and compares `good` and `crc_value` at the first negative edge where `busy` is low. For a follow-up check, it expects exactly one low sample between two busy windows.

// File: rtl/memcrc_pkg.sv
package memcrc_pkg;

   // sequencer phases: idle, issuing reads, waiting for the checksum byte
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_DRAIN = 2'd2
   } crc_state_e;

   localparam logic [7:0] CRC8_POLY_DEFAULT = 8'h07;
   localparam logic [7:0] CRC8_SEED_DEFAULT = 8'hFF;

endpackage

// File: rtl/memcrc_step.sv
// One-step CRC update for a full data word. NET_STYLE 0 builds a per-bit
// XOR network from masks derived at elaboration; 1 uses the unrolled loop.
module memcrc_step #(
   parameter int unsigned     W         = 8,
   parameter logic [W-1:0]    POLY      = 8'h07,
   parameter int unsigned     NET_STYLE = 0
) (
   input  logic [W-1:0] crc_in,
   input  logic [W-1:0] data_in,
   output logic [W-1:0] crc_out
);

   function automatic logic [W-1:0] serial_step(input logic [W-1:0] c,
                                                input logic [W-1:0] d);
      logic [W-1:0] r;
      r = c ^ d;
      for (int i = 0; i < int'(W); i++) begin
         if (r[W-1]) r = (r << 1) ^ POLY;
         else        r = r << 1;
      end
      return r;
   endfunction

   function automatic logic [W-1:0] col_mask(input int j, input bit from_data);
      logic [W-1:0] unit;
      logic [W-1:0] r;
      logic [W-1:0] m;
      m = '0;
      for (int k = 0; k < int'(W); k++) begin
         unit    = '0;
         unit[k] = 1'b1;
         r       = from_data ? serial_step('0, unit) : serial_step(unit, '0);
         m[k]    = r[j];
      end
      return m;
   endfunction

   if (NET_STYLE > 1) begin : g_bad_style
      $error("memcrc_step: NET_STYLE must be 0 or 1");
   end

   if (NET_STYLE == 0) begin : g_xor_net
      for (genvar j = 0; j < int'(W); j++) begin : g_bit
         localparam logic [W-1:0] CMASK = col_mask(j, 1'b0);
         localparam logic [W-1:0] DMASK = col_mask(j, 1'b1);
         assign crc_out[j] = (^(crc_in & CMASK)) ^ (^(data_in & DMASK));
      end
   end else begin : g_loop
      assign crc_out = serial_step(crc_in, data_in);
   end

endmodule

// File: rtl/memcrc_seq.sv
// Trigger latches, address walk and read-data qualification.
module memcrc_seq
   import memcrc_pkg::*;
#(
   parameter int unsigned ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              calc_set,
   output logic              calc_req,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              start,
   output logic              byte_vld,
   output logic              chk_vld,
   output logic              busy
);

   localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};

   crc_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              boot_pend_q;
   logic              wr_pend_q;
   logic              calc_q;
   logic              vld_q;
   logic              last_q;
   logic              wr_hit;

   assign wr_hit   = wr_en && (wr_addr == LAST);
   assign start    = (state_q == ST_IDLE) && (boot_pend_q || wr_pend_q || calc_q);
   assign rd_en    = (state_q == ST_READ);
   assign rd_addr  = addr_q;
   assign busy     = (state_q != ST_IDLE);
   assign calc_req = calc_q;
   assign byte_vld = vld_q && !last_q;
   assign chk_vld  = vld_q && last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         boot_pend_q <= 1'b1;
         wr_pend_q   <= 1'b0;
         calc_q      <= 1'b0;
         vld_q       <= 1'b0;
         last_q      <= 1'b0;
      end else begin
         boot_pend_q <= boot_pend_q && !start;
         wr_pend_q   <= start ? 1'b0 : (wr_pend_q || wr_hit);
         calc_q      <= start ? 1'b0 : (calc_q || calc_set);
         vld_q       <= rd_en;
         last_q      <= rd_en && (addr_q == LAST);
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_READ;
                  addr_q  <= '0;
               end
            end
            ST_READ: begin
               addr_q <= addr_q + ONE;
               if (addr_q == LAST) state_q <= ST_DRAIN;
            end
            ST_DRAIN: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/memcrc_engine.sv
module memcrc_engine
   import memcrc_pkg::*;
#(
   parameter int unsigned          ADDR_W    = 7,
   parameter int unsigned          DATA_W    = 8,
   parameter logic [DATA_W-1:0]    POLY      = CRC8_POLY_DEFAULT,
   parameter logic [DATA_W-1:0]    SEED      = CRC8_SEED_DEFAULT,
   parameter int unsigned          NET_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              calc_set,
   output logic              calc_req,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              good,
   output logic [DATA_W-1:0] crc_value
);

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("memcrc_engine: ADDR_W out of range 2..16");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("memcrc_engine: DATA_W must be at least 2");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("memcrc_engine: generator must have a constant term");
   end

   logic              start;
   logic              byte_vld;
   logic              chk_vld;
   logic [DATA_W-1:0] crc_q;
   logic [DATA_W-1:0] crc_nx;
   logic              good_q;
   logic [DATA_W-1:0] value_q;

   memcrc_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .calc_set (calc_set),
      .calc_req (calc_req),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .start    (start),
      .byte_vld (byte_vld),
      .chk_vld  (chk_vld),
      .busy     (busy)
   );

   memcrc_step #(.W(DATA_W), .POLY(POLY), .NET_STYLE(NET_STYLE)) u_step (
      .crc_in  (crc_q),
      .data_in (rd_data),
      .crc_out (crc_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q   <= SEED;
         good_q  <= 1'b0;
         value_q <= '0;
      end else begin
         if (start) begin
            crc_q  <= SEED;
            good_q <= 1'b0;
         end else if (byte_vld) begin
            crc_q  <= crc_nx;
         end
         if (chk_vld) begin
            good_q  <= (crc_q == rd_data);
            value_q <= crc_q;
         end
      end
   end

   assign good      = good_q;
   assign crc_value = value_q;

endmodule

// File: rtl/memcrc_chk.sv
module memcrc_chk #(
   parameter int unsigned ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              calc_req,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              busy,
   input logic              good
);

   localparam int unsigned       DEPTH = 1 << ADDR_W;
   localparam int unsigned       CW    = ADDR_W + 2;
   localparam logic [CW-1:0]     SPAN  = CW'(DEPTH + 1);
   localparam logic [ADDR_W-1:0] LAST  = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] ONE   = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   AST_GOOD_CLR_ON_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !good); // R6
   AST_GOOD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) !$stable(good) |-> ($rose(busy) || $fell(busy))); // R5
   AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (rd_en && rd_addr == '0)); // R7
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ONE)); // R7
   AST_READ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> busy); // R7
   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (busy_cnt == SPAN)); // R7
   AST_CALC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $fell(calc_req) |-> $rose(busy)); // R3
   AST_LAST_WRITE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_addr == LAST && !busy) |=> ##1 busy); // R2

endmodule

bind memcrc_engine memcrc_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .calc_req (calc_req),
   .rd_en    (rd_en),
   .rd_addr  (rd_addr),
   .busy     (busy),
   .good     (good)
);

// File: tb/sim_memcrc_engine.sv
module sim_memcrc_engine;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 7;
   localparam int DEPTH      = 1 << AW;
   localparam int LAST       = DEPTH - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          calc_set = 1'b0;
   logic          calc_req;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data;
   logic          busy;
   logic          good;
   logic [7:0]    crc_value;

   logic [7:0] mem    [DEPTH];
   logic [7:0] shadow [DEPTH];

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr];
   end

   memcrc_engine u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .calc_set  (calc_set),
      .calc_req  (calc_req),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .busy      (busy),
      .good      (good),
      .crc_value (crc_value)
   );

   // bit-serial reference: generator 0x07, seed 0xFF, msb first
   function automatic logic [7:0] ref_crc();
      logic [7:0] c;
      logic       fb;
      c = 8'hFF;
      for (int a = 0; a < LAST; a++) begin
         for (int b = 7; b >= 0; b--) begin
            fb = c[7] ^ shadow[a][b];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
         end
      end
      return c;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      wr_en   = 1'b1;
      wr_addr = AW'(a);
      wr_data = d;
      shadow[a] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic fill(input int mode);
      for (int a = 0; a < LAST; a++) begin
         if (mode == 0)      wr(a, 8'h00);
         else if (mode == 1) wr(a, 8'hFF);
         else                wr(a, 8'($urandom));
      end
   endtask

   task automatic pulse_calc();
      calc_set = 1'b1;
      @(negedge clk);
      calc_set = 1'b0;
   endtask

   task automatic run_to_done(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int n;
      logic [7:0] r;
      logic [7:0] v;
      bit corrupt;
      void'($urandom(32'd4242));

      // prime the array while the engine is held in reset
      @(negedge clk);
      fill(2);
      r = ref_crc();
      wr(LAST, r);
      chk("R1 busy in reset", int'(busy), 0);
      chk("R1 good in reset", int'(good), 0);
      chk("R1 calc_req in reset", int'(calc_req), 0);
      chk("R1 rd_en in reset", int'(rd_en), 0);

      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 boot check started", int'(busy), 1);
      run_to_done(n);
      chk("R7 boot busy length", n, DEPTH + 1);
      chk("R4 boot crc", int'(crc_value), int'(r));
      chk("R5 boot match", int'(good), 1);

      // non-last write: no launch, good untouched
      wr(10, shadow[10] ^ 8'h3C);
      for (int i = 0; i < 3; i++) begin
         chk("R2 no launch on other address", int'(busy), 0);
         chk("R2 good kept", int'(good), 1);
         @(negedge clk);
      end

      // software request
      pulse_calc();
      chk("R3 calc_req set", int'(calc_req), 1);
      chk("R9 not yet busy", int'(busy), 0);
      @(negedge clk);
      chk("R9 busy one edge later", int'(busy), 1);
      chk("R3 calc_req cleared at start", int'(calc_req), 0);
      chk("R6 good cleared at start", int'(good), 0);
      run_to_done(n);
      r = ref_crc();
      chk("R7 sw busy length", n, DEPTH + 1);
      chk("R4 sw crc", int'(crc_value), int'(r));
      chk("R5 sw stale checksum", int'(good), int'(r == shadow[LAST]));

      // last-byte write trigger restores a match
      wr(LAST, r);
      chk("R9 idle after last write", int'(busy), 0);
      @(negedge clk);
      chk("R2 last write launches", int'(busy), 1);
      run_to_done(n);
      chk("R5 match after rewrite", int'(good), 1);

      // back-to-back: triggers during a check merge into one follow-up
      pulse_calc();
      @(negedge clk);
      repeat (10) @(negedge clk);
      wr(LAST, r ^ 8'h5A);
      pulse_calc();
      chk("R8 calc held while busy", int'(calc_req), 1);
      run_to_done(n);
      chk("R5 first check sees corrupt byte", int'(good), 0);
      chk("R4 first check crc", int'(crc_value), int'(r));
      chk("R8 one idle cycle", int'(busy), 0);
      @(negedge clk);
      chk("R8 follow-up started", int'(busy), 1);
      chk("R6 good low in follow-up", int'(good), 0);
      run_to_done(n);
      chk("R8 follow-up length", n, DEPTH + 1);
      chk("R5 follow-up mismatch", int'(good), 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R8 merged, no third check", int'(busy), 0);
      end

      // patterned and random rounds
      for (int rnd = 0; rnd < 8; rnd++) begin
         fill(rnd < 2 ? rnd : 2);
         r = ref_crc();
         corrupt = 1'($urandom);
         v = corrupt ? (r ^ (8'h01 << ($urandom % 8))) : r;
         wr(LAST, v);
         @(negedge clk);
         chk("R2 random launch", int'(busy), 1);
         run_to_done(n);
         chk("R7 random length", n, DEPTH + 1);
         chk("R4 random crc", int'(crc_value), int'(r));
         chk("R5 random verdict", int'(good), int'(!corrupt));
         if (1'($urandom)) begin
            pulse_calc();
            @(negedge clk);
            run_to_done(n);
            chk("R3 random rerun crc", int'(crc_value), int'(r));
            chk("R5 random rerun verdict", int'(good), int'(!corrupt));
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule